// File: doc/BRIEF.md
# Pipelined Packed Word Multiplier

This block multiplies two 64-bit operands as four independent 16-bit lanes. Each lane pair produces a 32-bit product. Because that product cannot fit back into a 16-bit lane, the operation code picks what is returned:

- the low half of every product;
- the high half of every signed product;
- the high half of every unsigned product;
- a multiply-add that adds neighbouring signed products into two 32-bit sums.

Operations stream in on a valid strobe, at most one per clock. Each result comes out a fixed three cycles later on an output valid strobe. The operation code and the valid bit travel down the pipeline with the data, so different operations can be mixed on consecutive cycles.

There is no ready signal in either direction. The block never stalls and cannot refuse an operation. The consumer must take every result in the cycle where `out_valid` is high, because a result is not held any longer than that. A synchronous reset empties the pipeline and discards any operations still in flight.

Top module: `pmulw_pipe`

## Requirements
- R1: Operands and results are split into four independent 16-bit lanes, with lane i at bits 16i+15:16i. For the three per-lane operations, each result lane depends only on the same lane of both operands.
- R2: With `in_op` = 0, each result lane holds bits 15:0 of the product of its two operand lanes.
- R3: With `in_op` = 1, each result lane holds bits 31:16 of the product of its operand lanes, both read as two's-complement numbers.
- R4: With `in_op` = 2, each result lane holds bits 31:16 of the product of its operand lanes, both read as unsigned numbers.
- R5: With `in_op` = 3, the four signed lane products are added in pairs. Lanes 1 and 0 give bits 31:0 and lanes 3 and 2 give bits 63:32. Each sum wraps modulo 2^32 and is not saturated.
- R6: An operation presented with `in_valid` high in cycle t yields `out_valid` high and its `out_data` in cycle t+3. In any other cycle, `out_valid` is low.
- R7: A new operation is accepted on every cycle. Operations with different codes may follow one another back to back, and each result follows its own code.
- R8: While `rst` is high at a rising edge, every pipeline stage is emptied. `out_valid` is low in the following cycle, and no operation issued before the reset ever produces a result.
- R9: When `in_valid` is low, the operand and code inputs are ignored and produce no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | An operation is present this cycle |
| in_op | input | 2 | Operation code: 0 low half, 1 signed high half, 2 unsigned high half, 3 multiply-add |
| in_a | input | 64 | First packed operand |
| in_b | input | 64 | Second packed operand |
| out_valid | output | 1 | A result is present this cycle |
| out_data | output | 64 | Packed result |

## Verification
The sweep pairs the edge values 0x0000, 0x0001, 0x7FFF, 0x8000, 0x8001 and 0xFFFF across the lanes, with the operation code changing on every cycle. This catches four kinds of fault:

- A design that sign-extends in the unsigned high-half mode, or zero-extends in the signed one, returns wrong upper halves for any lane with bit 15 set.
- A design that lets the opcode fall out of step with its data applies one operation to the operands of its neighbour.
- A design that saturates the multiply-add, or pairs the wrong lanes, fails where two products of 0x8000×0x8000 add to 0x80000000.

Random streams with gaps, and a reset in the middle of a stream, show whether results are lost, duplicated or released from before the reset.

// File: rtl/pmulw_pkg.sv
package pmulw_pkg;
  typedef enum logic [1:0] {
    OPC_LO  = 2'd0,
    OPC_HIS = 2'd1,
    OPC_HIU = 2'd2,
    OPC_MAC = 2'd3
  } pmulw_op_e;

  // Operand lanes are read as signed for these codes.
  function automatic logic op_signed(pmulw_op_e op);
    return (op == OPC_HIS) || (op == OPC_MAC);
  endfunction
endpackage

// File: rtl/pmulw_lane.sv
module pmulw_lane #(
  parameter int W = 16
) (
  input  logic             clk,
  input  logic [W-1:0]     a,
  input  logic [W-1:0]     b,
  input  logic             sgn,
  output logic [2*W-1:0]   prod
);
  localparam int PW = 2 * W;

  logic signed [W:0] ea;
  logic signed [W:0] eb;
  logic [PW-1:0]     prod_c;

  // One extra bit selects signed or unsigned reading of each operand.
  assign ea     = {sgn & a[W-1], a};
  assign eb     = {sgn & b[W-1], b};
  assign prod_c = PW'(ea * eb);

  always_ff @(posedge clk) begin
    prod <= prod_c;
  end
endmodule

// File: rtl/pmulw_merge.sv
module pmulw_merge
  import pmulw_pkg::*;
#(
  parameter int LANES = 4,
  parameter int W     = 16
) (
  input  pmulw_op_e                    op,
  input  logic [LANES-1:0][2*W-1:0]    prods,
  output logic [LANES*W-1:0]           res
);
  localparam int PW    = 2 * W;
  localparam int PAIRS = LANES / 2;

  logic [LANES*W-1:0] lo_v;
  logic [LANES*W-1:0] hi_v;
  logic [LANES*W-1:0] mac_v;

  for (genvar i = 0; i < LANES; i++) begin : g_half
    assign lo_v[i*W +: W] = prods[i][W-1:0];
    assign hi_v[i*W +: W] = prods[i][PW-1:W];
  end

  // Products are already reduced modulo 2^PW, so the pair sum wraps correctly.
  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    assign mac_v[p*PW +: PW] = prods[2*p] + prods[2*p+1];
  end

  always_comb begin
    case (op)
      OPC_LO:  res = lo_v;
      OPC_HIS: res = hi_v;
      OPC_HIU: res = hi_v;
      default: res = mac_v;
    endcase
  end
endmodule

// File: rtl/pmulw_pipe.sv
module pmulw_pipe
  import pmulw_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int LANE_W = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  input  logic [1:0]                in_op,
  input  logic [LANES*LANE_W-1:0]   in_a,
  input  logic [LANES*LANE_W-1:0]   in_b,
  output logic                      out_valid,
  output logic [LANES*LANE_W-1:0]   out_data
);
  localparam int DW = LANES * LANE_W;
  localparam int PW = 2 * LANE_W;

  // Stage 1: operand capture
  logic       s1_v;
  pmulw_op_e  s1_op;
  logic [DW-1:0] s1_a;
  logic [DW-1:0] s1_b;

  always_ff @(posedge clk) begin
    if (rst) s1_v <= 1'b0;
    else     s1_v <= in_valid;
    s1_op <= pmulw_op_e'(in_op);
    s1_a  <= in_a;
    s1_b  <= in_b;
  end

  // Stage 2: lane products (registered inside each lane)
  logic                      s2_v;
  pmulw_op_e                 s2_op;
  logic [LANES-1:0][PW-1:0]  s2_prod;
  logic                      s1_sgn;

  assign s1_sgn = op_signed(s1_op);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    pmulw_lane #(.W(LANE_W)) u_lane (
      .clk  (clk),
      .a    (s1_a[i*LANE_W +: LANE_W]),
      .b    (s1_b[i*LANE_W +: LANE_W]),
      .sgn  (s1_sgn),
      .prod (s2_prod[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) s2_v <= 1'b0;
    else     s2_v <= s1_v;
    s2_op <= s1_op;
  end

  // Stage 3: half select or pair sum
  logic [DW-1:0] s2_res;

  pmulw_merge #(.LANES(LANES), .W(LANE_W)) u_merge (
    .op    (s2_op),
    .prods (s2_prod),
    .res   (s2_res)
  );

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= s2_v;
    out_data <= s2_res;
  end
endmodule

// File: rtl/pmulw_chk.sv
module pmulw_chk #(
  parameter int LANES  = 4,
  parameter int LANE_W = 16
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      in_valid,
  input logic [1:0]                in_op,
  input logic [LANES*LANE_W-1:0]   in_a,
  input logic [LANES*LANE_W-1:0]   in_b,
  input logic                      out_valid,
  input logic [LANES*LANE_W-1:0]   out_data
);
  // Edges since reset, saturating at the pipeline depth.
  logic [1:0] since;

  always_ff @(posedge clk) begin
    if (rst)               since <= 2'd0;
    else if (since != 2'd3) since <= since + 2'd1;
  end

  logic ready3;
  assign ready3 = (since == 2'd3);

  // R6
  lat_valid_chk: assert property (@(posedge clk) disable iff (rst)
    ready3 |-> (out_valid == $past(in_valid, 3)));

  // R8
  rst_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> !out_valid);

  // R2
  lo_lane0_chk: assert property (@(posedge clk) disable iff (rst)
    (ready3 && out_valid && $past(in_op, 3) == 2'd0) |->
      (out_data[15:0] == 16'($past(in_a[15:0], 3) * $past(in_b[15:0], 3))));

  // R4
  hiu_lane3_chk: assert property (@(posedge clk) disable iff (rst)
    (ready3 && out_valid && $past(in_op, 3) == 2'd2) |->
      (out_data[63:48] == 16'((32'($past(in_a[63:48], 3)) * 32'($past(in_b[63:48], 3))) >> 16)));

  // R5
  mac_pair0_chk: assert property (@(posedge clk) disable iff (rst)
    (ready3 && out_valid && $past(in_op, 3) == 2'd3) |->
      (out_data[31:0] == 32'(
         $signed(32'($signed($past(in_a[15:0], 3)) * $signed($past(in_b[15:0], 3)))) +
         $signed(32'($signed($past(in_a[31:16], 3)) * $signed($past(in_b[31:16], 3)))))));
endmodule

bind pmulw_pipe pmulw_chk #(.LANES(LANES), .LANE_W(LANE_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_op     (in_op),
  .in_a      (in_a),
  .in_b      (in_b),
  .out_valid (out_valid),
  .out_data  (out_data)
);

// File: tb/pmulw_pipe_test.sv
`timescale 1ns/1ps
module pmulw_pipe_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [1:0]  in_op = 2'd0;
  logic [63:0] in_a = '0;
  logic [63:0] in_b = '0;
  logic        out_valid;
  logic [63:0] out_data;

  always #2.5 clk = ~clk;

  pmulw_pipe uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_data(out_data)
  );

  int checks = 0;
  int errors = 0;
  bit mon = 1'b0;
  bit ended = 1'b0;

  // Result computed arithmetically from R1..R5.
  function automatic logic [63:0] model(logic [1:0] op, logic [63:0] a, logic [63:0] b);
    logic [63:0] r = '0;
    longint sa[4];
    longint sb[4];
    longint ua[4];
    longint ub[4];
    for (int i = 0; i < 4; i++) begin
      sa[i] = longint'($signed(a[16*i +: 16]));
      sb[i] = longint'($signed(b[16*i +: 16]));
      ua[i] = longint'(a[16*i +: 16]);
      ub[i] = longint'(b[16*i +: 16]);
    end
    case (op)
      2'd0: for (int i = 0; i < 4; i++) r[16*i +: 16] = 16'(ua[i] * ub[i]);
      2'd1: for (int i = 0; i < 4; i++) r[16*i +: 16] = 16'((sa[i] * sb[i]) >>> 16);
      2'd2: for (int i = 0; i < 4; i++) r[16*i +: 16] = 16'((ua[i] * ub[i]) >> 16);
      default: begin
        r[31:0]  = 32'(sa[0] * sb[0] + sa[1] * sb[1]);
        r[63:32] = 32'(sa[2] * sb[2] + sa[3] * sb[3]);
      end
    endcase
    return r;
  endfunction

  function automatic string op_tag(logic [1:0] op);
    case (op)
      2'd0: return "R1/R2";
      2'd1: return "R1/R3";
      2'd2: return "R1/R4";
      default: return "R5";
    endcase
  endfunction

  // Expected pipeline: three-cycle valid history (R6, R9), cleared by reset (R8).
  logic [2:0]  vh = '0;
  logic [63:0] ed [3];
  logic [1:0]  eo [3];

  always @(posedge clk) begin
    if (rst) vh <= '0;
    else     vh <= {vh[1:0], in_valid};
    ed[2] <= ed[1]; ed[1] <= ed[0]; ed[0] <= model(in_op, in_a, in_b);
    eo[2] <= eo[1]; eo[1] <= eo[0]; eo[0] <= in_op;
  end

  always @(negedge clk) begin
    if (mon) begin
      checks++;
      if (out_valid !== vh[2]) begin
        errors++;
        $display("FAIL R6/R9: out_valid actual %b expected %b", out_valid, vh[2]);
      end else if (vh[2]) begin
        checks++;
        if (out_data !== ed[2]) begin
          errors++;
          $display("FAIL %s R7: out_data actual %h expected %h", op_tag(eo[2]), out_data, ed[2]);
        end
      end
    end
  end

  task automatic issue(bit v, logic [1:0] op, logic [63:0] a, logic [63:0] b);
    @(posedge clk); #1;
    in_valid = v; in_op = op; in_a = a; in_b = b;
  endtask

  function automatic logic [15:0] cv(int k);
    case (k % 8)
      0: return 16'h0000;
      1: return 16'h0001;
      2: return 16'h7FFF;
      3: return 16'h8000;
      4: return 16'h8001;
      5: return 16'hFFFF;
      6: return 16'h1234;
      default: return 16'hFEDC;
    endcase
  endfunction

  task automatic summary();
    if (!ended) begin
      ended = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5.0);
    errors++;
    $display("FAIL watchdog: run did not complete, actual timeout expected finish");
    summary();
  end

  initial begin
    logic [63:0] a;
    logic [63:0] b;
    // Reset state (R8)
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R8: out_valid after reset actual %b expected 0", out_valid);
    end
    mon = 1'b1;
    @(posedge clk); #1; rst = 1'b0;

    // Edge-value sweep, opcode changing every cycle (R1..R5, R7)
    for (int x = 0; x < 8; x++)
      for (int y = 0; y < 8; y++)
        for (int op = 0; op < 4; op++) begin
          for (int i = 0; i < 4; i++) begin
            a[16*i +: 16] = cv(x + i);
            b[16*i +: 16] = cv(y + 3 * i);
          end
          issue(1'b1, 2'(op), a, b);
        end

    // Worst-case pair sum: 0x8000*0x8000 twice wraps to 0x80000000 (R5)
    issue(1'b1, 2'd3, 64'h8000_8000_8000_8000, 64'h8000_8000_8000_8000);

    // Random stream with gaps; idle cycles carry garbage (R9)
    for (int n = 0; n < 400; n++)
      issue(($urandom % 3) != 0, 2'($urandom),
            {$urandom, $urandom}, {$urandom, $urandom});
    issue(1'b0, 2'd0, '0, '0);
    repeat (4) @(posedge clk);

    // Reset with operations in flight (R8)
    issue(1'b1, 2'd1, 64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888);
    issue(1'b1, 2'd3, 64'hFFFF_0001_8000_7FFF, 64'h0002_FFFF_8000_7FFF);
    @(posedge clk); #1; rst = 1'b1; in_valid = 1'b1;
    @(posedge clk); #1; rst = 1'b0; in_valid = 1'b0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      checks++;
      if (out_valid !== 1'b0) begin
        errors++;
        $display("FAIL R8: result escaped reset, out_valid actual %b expected 0", out_valid);
      end
    end

    // Back-to-back after reset (R7)
    issue(1'b1, 2'd2, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF);
    issue(1'b1, 2'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF);
    issue(1'b1, 2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF);
    issue(1'b0, 2'd0, '0, '0);
    repeat (5) @(posedge clk);
    @(negedge clk);
    summary();
  end
endmodule